// File: doc/BRIEF.md
# Dual-Compare Programmable Interval Timer

A 16-bit up-counting interval timer, programmed through a small register port with four word addresses: a mode/control word, the live count and two compare limits, A and B. The count can advance on an internal tick that fires once every four clocks, on a prescale tick from a neighbouring timer, or on rising edges of an external timer input. When the timer is not counting external edges, that input works either as a level gate or as an edge that restarts the count.

The count is compared against the active limit on each tick. When the next value would reach that limit, the count returns to zero and a sticky status flag is set. An interrupt request can also be raised, and it stays high until it is acknowledged. In dual-compare mode the timer alternates between limits A and B, and a read-only bit shows which limit is active. With the continuous bit clear, the timer disables itself at the end of one full cycle. The enable bit can only be changed by a write that sets a companion bit in the same data word, so other control fields can be updated without touching the enable.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, every register reads 0 and irq_o is low. The register map is addr_i 0 = control, 1 = count, 2 = compare A, 3 = compare B. Register reads are combinational.
- R2: Control bit 15 (enable) changes on a write only if bit 14 of the write data is 1. Bit 14 always reads 0, as do bits 11..6. Bit 12 cannot be written.
- R3: With EXT (bit 2) = 0, P (bit 3) = 0, RTG (bit 4) = 0 and the input held high, an enabled count advances exactly once per four clocks.
- R4: With P = 1 and EXT = 0, the count advances once for each clock in which prescale_tick_i is high.
- R5: With RTG = 0 and EXT = 0, a low timer input freezes the count.
- R6: With RTG = 1 and EXT = 0, a rising edge on the timer input clears the count. In this mode the input level does not gate counting.
- R7: With EXT = 1, the count advances once per rising edge of the timer input (after a two-flop synchronizer). prescale_tick_i and RTG have no effect.
- R8: On a tick where count+1 equals the active compare value, the count goes to 0 and MC (bit 5) is set, whatever the value of INT.
- R9: With INT (bit 13) = 1, a match raises irq_o. irq_o then stays high until a cycle with irq_ack_i high, even if enable is cleared first. With INT = 0, a match leaves irq_o low.
- R10: With ALT (bit 1) = 1, each match toggles RIU (bit 12). RIU = 0 compares against A and RIU = 1 against B. Writing ALT = 0 returns RIU to 0.
- R11: With CONT (bit 0) = 0, enable clears on the match that ends a cycle: the B match in dual mode, the A match otherwise. With CONT = 1, counting continues.
- R12: MC is cleared only by a control write with bit 5 = 0. Writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register word select |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| tmr_in_i | input | 1 | Timer input pin (asynchronous) |
| prescale_tick_i | input | 1 | One-clock tick from the companion timer |
| irq_ack_i | input | 1 | Clears the pending interrupt request |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong tick source or gate decision shows up in the count register within a few ticks, as a count that moved when it should have frozen, or moved at the wrong rate. A wrong active-limit pointer shows up at the next match, either through RIU or through the count wrapping at the wrong value. Stale enable or flag state appears one cycle after the match: enable does not drop, MC does not set, or irq_o falls before it is acknowledged. Randomly chosen limits and tick counts are compared against the residue of the tick count modulo the limit.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned CW = 16;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CMPA = 2'd2;
  localparam logic [1:0] A_CMPB = 2'd3;

  localparam int unsigned B_EN   = 15;
  localparam int unsigned B_INH  = 14;
  localparam int unsigned B_INT  = 13;
  localparam int unsigned B_RIU  = 12;
  localparam int unsigned B_MC   = 5;
  localparam int unsigned B_RTG  = 4;
  localparam int unsigned B_P    = 3;
  localparam int unsigned B_EXT  = 2;
  localparam int unsigned B_ALT  = 1;
  localparam int unsigned B_CONT = 0;

  typedef struct packed {
    logic en;
    logic intr;
    logic riu;
    logic mc;
    logic rtg;
    logic presc;
    logic ext;
    logic alt;
    logic cont;
  } ctrl_t;

  function automatic logic [CW-1:0] ctrl_pack(input ctrl_t c);
    logic [CW-1:0] w;
    w         = '0;
    w[B_EN]   = c.en;
    w[B_INT]  = c.intr;
    w[B_RIU]  = c.riu;
    w[B_MC]   = c.mc;
    w[B_RTG]  = c.rtg;
    w[B_P]    = c.presc;
    w[B_EXT]  = c.ext;
    w[B_ALT]  = c.alt;
    w[B_CONT] = c.cont;
    return w;
  endfunction
endpackage

// File: rtl/dct_in_sync.sv
module dct_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dct_tick_gen.sv
module dct_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic rtg_i,
  input  logic presc_i,
  input  logic level_i,
  input  logic rise_i,
  input  logic prescale_tick_i,
  output logic tick_o,
  output logic retrig_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;
  logic          int_tick, base_tick;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;

  assign int_tick  = (div_q == LAST);
  assign base_tick = presc_i ? prescale_tick_i : int_tick;

  always_comb begin
    if (ext_i)      tick_o = rise_i;
    else if (rtg_i) tick_o = base_tick;
    else            tick_o = base_tick & level_i;
  end

  assign retrig_o = ~ext_i & rtg_i & rise_i;
endmodule

// File: rtl/dct_ctrl_reg.sv
module dct_ctrl_reg
  import dct_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          match_i,
  input  logic          irq_ack_i,
  output ctrl_t         ctrl_o,
  output logic          irq_o
);
  ctrl_t ctrl_q;
  logic  irq_q;
  logic  cycle_end;

  assign cycle_end = ~ctrl_q.cont & (~ctrl_q.alt | ctrl_q.riu);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_i) begin
        if (wdata_i[B_INH]) ctrl_q.en <= wdata_i[B_EN];
        ctrl_q.intr  <= wdata_i[B_INT];
        ctrl_q.mc    <= ctrl_q.mc & wdata_i[B_MC];
        ctrl_q.rtg   <= wdata_i[B_RTG];
        ctrl_q.presc <= wdata_i[B_P];
        ctrl_q.ext   <= wdata_i[B_EXT];
        ctrl_q.alt   <= wdata_i[B_ALT];
        ctrl_q.cont  <= wdata_i[B_CONT];
        if (!wdata_i[B_ALT]) ctrl_q.riu <= 1'b0;
      end
      // hardware events win over a same-cycle write
      if (match_i) begin
        ctrl_q.mc <= 1'b1;
        if (ctrl_q.alt) ctrl_q.riu <= ~ctrl_q.riu;
        if (cycle_end)  ctrl_q.en  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                      irq_q <= 1'b0;
    else if (match_i && ctrl_q.intr)  irq_q <= 1'b1;
    else if (irq_ack_i)               irq_q <= 1'b0;

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_cnt_i,
  input  logic         wr_cmpa_i,
  input  logic         wr_cmpb_i,
  input  logic [W-1:0] wdata_i,
  input  logic         en_i,
  input  logic         use_b_i,
  input  logic         tick_i,
  input  logic         retrig_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] cmpa_o,
  output logic [W-1:0] cmpb_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q, cmpa_q, cmpb_q, nxt, limit;
  logic         adv;

  assign limit   = use_b_i ? cmpb_q : cmpa_q;
  assign nxt     = cnt_q + 1'b1;
  assign adv     = en_i & tick_i & ~retrig_i & ~wr_cnt_i;
  assign match_o = adv & (nxt == limit);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_cnt_i) cnt_q <= wdata_i;
    else if (retrig_i) cnt_q <= '0;
    else if (match_o)  cnt_q <= '0;
    else if (adv)      cnt_q <= nxt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (wr_cmpa_i) cmpa_q <= wdata_i;
      if (wr_cmpb_i) cmpb_q <= wdata_i;
    end

  assign count_o = cnt_q;
  assign cmpa_o  = cmpa_q;
  assign cmpb_o  = cmpb_q;
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int unsigned DIV    = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  input  logic          tmr_in_i,
  input  logic          prescale_tick_i,
  input  logic          irq_ack_i,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic          level, rise, tick, retrig, match;
  logic [CW-1:0] count, cmpa, cmpb;
  logic          wr_ctrl, wr_cnt, wr_cmpa, wr_cmpb;

  assign wr_ctrl = wr_en_i & (addr_i == A_CTRL);
  assign wr_cnt  = wr_en_i & (addr_i == A_CNT);
  assign wr_cmpa = wr_en_i & (addr_i == A_CMPA);
  assign wr_cmpb = wr_en_i & (addr_i == A_CMPB);

  dct_in_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i(tmr_in_i), .level_o(level), .rise_o(rise)
  );

  dct_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i, .rst_ni,
    .ext_i(ctrl.ext), .rtg_i(ctrl.rtg), .presc_i(ctrl.presc),
    .level_i(level), .rise_i(rise), .prescale_tick_i,
    .tick_o(tick), .retrig_o(retrig)
  );

  dct_counter #(.W(CW)) u_cnt (
    .clk_i, .rst_ni,
    .wr_cnt_i(wr_cnt), .wr_cmpa_i(wr_cmpa), .wr_cmpb_i(wr_cmpb),
    .wdata_i, .en_i(ctrl.en), .use_b_i(ctrl.riu),
    .tick_i(tick), .retrig_i(retrig),
    .count_o(count), .cmpa_o(cmpa), .cmpb_o(cmpb), .match_o(match)
  );

  dct_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr_ctrl), .wdata_i,
    .match_i(match), .irq_ack_i, .ctrl_o(ctrl), .irq_o
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_pack(ctrl);
      A_CNT:   rdata_o = count;
      A_CMPA:  rdata_o = cmpa;
      default: rdata_o = cmpb;
    endcase
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  addr_i,
  input logic        wr_en_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic        irq_ack_i,
  input logic        irq_o,
  input logic        en,
  input logic        mc,
  input logic        riu,
  input logic        alt,
  input logic        match,
  input logic [15:0] count
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en_i && addr_i == 2'd0;

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> (rdata_o[14] == 1'b0 && rdata_o[11:6] == 6'd0)); // R2

  AST_EN_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !wdata_i[14] && !match) |=> (en == $past(en))); // R2

  AST_MATCH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> (count == 16'd0 && mc)); // R8

  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o); // R9

  AST_RIU_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && alt) |=> (riu != $past(riu))); // R10

  AST_MC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc && !(wr_ctrl && !wdata_i[5])) |=> mc); // R12
endmodule

bind dual_cmp_timer dct_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_ack_i(irq_ack_i), .irq_o(irq_o),
  .en(ctrl.en), .mc(ctrl.mc), .riu(ctrl.riu), .alt(ctrl.alt),
  .match(match), .count(count)
);

// File: tb/sim_dual_cmp_timer.sv
`timescale 1ns/1ps
module sim_dual_cmp_timer;
  localparam logic [15:0] F_EN = 16'h8000, F_INH = 16'h4000, F_INT = 16'h2000,
                          F_RIU = 16'h1000, F_MC = 16'h0020, F_RTG = 16'h0010,
                          F_P = 16'h0008, F_EXT = 16'h0004, F_ALT = 16'h0002,
                          F_CONT = 16'h0001;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tmr_in = 1'b0, presc = 1'b0, ack = 1'b0;
  logic        irq;
  int          checks = 0, errors = 0, cycles = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dual_cmp_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .tmr_in_i(tmr_in),
    .prescale_tick_i(presc), .irq_ack_i(ack), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [15:0] rd(input logic [1:0] a);
    addr = a;
    return rdata;
  endfunction

  task automatic rdv(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic ptick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); presc = 1'b1;
      @(negedge clk); presc = 1'b0;
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_residue(input int n, input int lim);
    return 16'(n % lim);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v0;
    process::self().srandom(32'd1234);
    waitc(3);
    rst_n = 1'b1;
    waitc(2);

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rdv(2'(a), v); chk("R1 reset reg", v, 16'h0000);
    end
    chk("R1 irq reset", {15'd0, irq}, 16'd0);

    // R2 enable guarded by bit 14
    wr(2'd2, 16'd100);
    wr(2'd0, F_EN | F_P | F_CONT | 16'h0FC0 | F_RIU);
    rdv(2'd0, v); chk("R2 en w/o inh, rsvd, riu", v, F_P | F_CONT);
    wr(2'd0, F_EN | F_INH | F_P | F_CONT);
    rdv(2'd0, v); chk("R2 en with inh, inh reads 0", v, F_EN | F_P | F_CONT);

    // R4 prescale ticks
    tmr_in = 1'b1; waitc(4);
    wr(2'd1, 16'd0);
    ptick(7);
    rdv(2'd1, v); chk("R4 prescale count", v, 16'd7);

    // R5 gate low freezes
    tmr_in = 1'b0; waitc(4);
    ptick(5);
    rdv(2'd1, v); chk("R5 gated freeze", v, 16'd7);

    // R3 internal divide by four
    tmr_in = 1'b1; waitc(4);
    wr(2'd0, F_EN | F_INH | F_CONT);
    rdv(2'd1, v0);
    waitc(40);
    rdv(2'd1, v); chk("R3 div4 rate", v - v0, 16'd10);

    // R6 retrigger
    wr(2'd0, F_EN | F_INH | F_P | F_RTG | F_CONT);
    tmr_in = 1'b0; waitc(4);
    wr(2'd1, 16'd0);
    ptick(5);
    rdv(2'd1, v); chk("R6 level ignored", v, 16'd5);
    tmr_in = 1'b1; waitc(5);
    rdv(2'd1, v); chk("R6 edge clears", v, 16'd0);

    // R7 external edges
    tmr_in = 1'b0; waitc(4);
    wr(2'd0, F_EN | F_INH | F_EXT | F_RTG | F_P | F_CONT);
    wr(2'd1, 16'd0);
    begin
      int n;
      n = 3 + int'($urandom % 6);
      for (int i = 0; i < n; i++) begin
        tmr_in = 1'b1; waitc(4); tmr_in = 1'b0; waitc(4);
      end
      rdv(2'd1, v); chk("R7 ext edge count", v, 16'(n));
      ptick(4);
      rdv(2'd1, v); chk("R7 prescale ignored", v, 16'(n));
    end
    tmr_in = 1'b1; waitc(4);

    // R8 random limits vs residue model
    for (int it = 0; it < 8; it++) begin
      int lim, n;
      lim = 2 + int'($urandom % 7);
      n   = int'($urandom % 20);
      wr(2'd0, F_INH | F_P | F_CONT);
      wr(2'd2, 16'(lim));
      wr(2'd1, 16'd0);
      wr(2'd0, F_EN | F_INH | F_P | F_CONT);
      ptick(n);
      rdv(2'd1, v); chk("R8 residue", v, exp_residue(n, lim));
      rdv(2'd0, v); chk("R8 mc flag", v & F_MC, (n >= lim) ? F_MC : 16'd0);
    end

    // R12 mc sticky
    wr(2'd2, 16'd2); wr(2'd1, 16'd0);
    wr(2'd0, F_EN | F_INH | F_P | F_CONT);
    ptick(2);
    wr(2'd0, F_P | F_CONT | F_MC);
    rdv(2'd0, v); chk("R12 write1 keeps mc", v & F_MC, F_MC);
    wr(2'd0, F_P | F_CONT);
    rdv(2'd0, v); chk("R12 write0 clears mc", v & F_MC, 16'd0);
    wr(2'd0, F_P | F_CONT | F_MC);
    rdv(2'd0, v); chk("R12 write1 no set", v & F_MC, 16'd0);

    // R9 interrupt
    wr(2'd1, 16'd0);
    wr(2'd0, F_EN | F_INH | F_INT | F_P | F_CONT);
    ptick(2);
    chk("R9 irq raised", {15'd0, irq}, 16'd1);
    wr(2'd0, F_INH | F_INT | F_P | F_CONT);
    waitc(3);
    chk("R9 irq held after disable", {15'd0, irq}, 16'd1);
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R9 irq acked", {15'd0, irq}, 16'd0);
    wr(2'd1, 16'd0);
    wr(2'd0, F_EN | F_INH | F_P | F_CONT);
    ptick(2);
    chk("R9 no irq when INT=0", {15'd0, irq}, 16'd0);
    rdv(2'd0, v); chk("R8 mc without INT", v & F_MC, F_MC);

    // R10 alternating limits
    wr(2'd2, 16'd3); wr(2'd3, 16'd5); wr(2'd1, 16'd0);
    wr(2'd0, F_EN | F_INH | F_P | F_ALT | F_CONT);
    ptick(3);
    rdv(2'd0, v); chk("R10 riu after A", v & F_RIU, F_RIU);
    ptick(2);
    rdv(2'd1, v); chk("R10 counting toward B", v, 16'd2);
    ptick(3);
    rdv(2'd0, v); chk("R10 riu after B", v & F_RIU, 16'd0);
    rdv(2'd1, v); chk("R10 count wrapped at B", v, 16'd0);

    // R11 single shot, single compare
    wr(2'd0, F_INH | F_P);
    wr(2'd2, 16'd4); wr(2'd1, 16'd0);
    wr(2'd0, F_EN | F_INH | F_P);
    ptick(4);
    rdv(2'd0, v); chk("R11 en off after A", v & F_EN, 16'd0);
    ptick(2);
    rdv(2'd1, v); chk("R11 stopped count", v, 16'd0);

    // R11 single shot, dual compare
    wr(2'd2, 16'd2); wr(2'd3, 16'd3); wr(2'd1, 16'd0);
    wr(2'd0, F_EN | F_INH | F_P | F_ALT);
    ptick(2);
    rdv(2'd0, v); chk("R11 en kept after A in dual", v & (F_EN | F_RIU), F_EN | F_RIU);
    ptick(3);
    rdv(2'd0, v); chk("R11 en off after B", v & F_EN, 16'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule